// File: doc/BRIEF.md
# Edge-Triggered Logic Capture Controller

This block is the capture core of a logic analyzer. It watches a parallel bus of probe channels and, once armed, waits for a trigger. A trigger can come from an edge on any probe channel, from an edge on an external trigger pin, or from software. Each probe channel has its own rising-edge enable and falling-edge enable. When the trigger fires, the block stores a fixed number of consecutive samples, starting with the sample that caused the trigger.

Once the buffer is full, a reader pulls the stored samples out one 32-bit word per request. Within each sample the lowest channels come first. A status word shows the phase of the engine: armed, capturing, filled, and whether data is still waiting. Everything runs on one clock with synchronous reset.

Top module: `logic_capture_ctrl`

## Requirements
- R1: Asserting `rst`, or setting control bit 1, returns the engine to idle within one clock. In idle, `status` is zero, `full` is low and `rd_valid` is low.
- R2: With control bit 0 set and bit 1 clear, an idle engine arms on the next clock. While armed, `status` reads 4 (bit 2 set, bits 1 and 0 clear).
- R3: While armed with control bit 2 clear, a channel c whose bit c is set in `rise_en` fires the trigger when its sample goes from 0 to 1 between consecutive clocks. Bit c belongs to 32-bit word c/32, at position c%32. The sample that shows the edge becomes buffer entry 0.
- R4: While armed with control bit 2 clear, a channel c whose bit c is set in `fall_en` fires the trigger when its sample goes from 1 to 0. Capture starts on that sample.
- R5: An edge on a channel whose enable bit for that direction is clear does not trigger, and the engine stays armed (`status` = 4).
- R6: With control bit 2 set, only `ext_trig` is a trigger source. A 0-to-1 transition fires when control bit 3 is 1, and a 1-to-0 transition fires when bit 3 is 0. Edges on the probe channels are ignored.
- R7: A 0-to-1 transition of control bit 4 while armed fires the trigger, whatever source is selected. Holding bit 4 high does not fire again. An edge on bit 4 seen while idle is used up and does not fire later.
- R8: After the trigger, exactly DEPTH consecutive samples are stored. `full` rises on the clock after the last one is written. While full, status bit 1 is 1 and status bit 2 is 0.
- R9: Read-out order is sample 0 to DEPTH-1, and within each sample 32-bit word 0 (channels 0..31) first, with unused upper channel bits read as 0. Each `rd_next` taken while `rd_valid` is high advances by one word. `rd_data` holds steady otherwise. After the last word, `rd_valid` and status bit 0 fall.
- R10: Clearing control bit 0 returns the engine to idle on the next clock, even during a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_in | input | CHANNELS | Probe channel samples |
| ext_trig | input | 1 | External trigger pin |
| ctrl | input | 32 | Control: 0 enable, 1 reset, 2 external source, 3 external polarity (1 rising), 4 software trigger |
| rise_en | input | 256 | Rising-edge enable per channel, bit c for channel c |
| fall_en | input | 256 | Falling-edge enable per channel, bit c for channel c |
| rd_next | input | 1 | Advance to the next read word |
| rd_data | output | 32 | Current read word |
| rd_valid | output | 1 | A read word is available |
| full | output | 1 | Capture buffer complete |
| status | output | 32 | Bit 0 data ready, bit 1 triggered, bit 2 armed or capturing |

## Verification
A software trigger edge and an enabled channel edge are driven in the same cycle. The test passes only if exactly one capture results: DEPTH samples starting from that cycle, read back with the exact word count and nothing extra in the scoreboard. With the external source selected, an enabled channel edge is placed a cycle apart from the external edge and must leave the engine armed. Disabling the engine in the middle of a capture must beat the capture logic and bring `status` to zero on the next clock.

// File: rtl/logic_capture_ctrl.sv
module logic_capture_ctrl #(
  parameter int CHANNELS = 32,
  parameter int DEPTH    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] probe_in,
  input  logic                ext_trig,
  input  logic [31:0]         ctrl,
  input  logic [255:0]        rise_en,
  input  logic [255:0]        fall_en,
  input  logic                rd_next,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  output logic                full,
  output logic [31:0]         status
);

  localparam int WORDS = (CHANNELS + 31) / 32;
  localparam int PADW  = WORDS * 32;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAPT, ST_DONE} phase_t;

  phase_t               state;
  logic [CHANNELS-1:0]  prev;
  logic                 ext_prev, sw_prev;
  logic [AW-1:0]        wptr, rsample;
  logic [WW-1:0]        rword;
  logic                 rdone;
  logic [PADW-1:0]      mem [DEPTH];
  logic [PADW-1:0]      pad_in;

  logic chan_hit, ext_hit, sw_hit, fire, clr;

  assign chan_hit = |((probe_in & ~prev & rise_en[CHANNELS-1:0]) |
                      (~probe_in & prev & fall_en[CHANNELS-1:0]));
  assign ext_hit  = ctrl[3] ? (ext_trig & ~ext_prev) : (~ext_trig & ext_prev);
  assign sw_hit   = ctrl[4] & ~sw_prev;
  assign fire     = (ctrl[2] ? ext_hit : chan_hit) | sw_hit;
  assign clr      = rst | ctrl[1] | ~ctrl[0];

  always_comb begin
    pad_in = '0;
    pad_in[CHANNELS-1:0] = probe_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= '0;
      ext_prev <= 1'b0;
      sw_prev  <= 1'b0;
    end else begin
      prev     <= probe_in;
      ext_prev <= ext_trig;
      sw_prev  <= ctrl[4];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      wptr    <= '0;
      rsample <= '0;
      rword   <= '0;
      rdone   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:  state <= ST_ARMED;
        ST_ARMED: if (fire) begin
          mem[0] <= pad_in;
          wptr   <= AW'(1);
          state  <= ST_CAPT;
        end
        ST_CAPT: begin
          mem[wptr] <= pad_in;
          if (wptr == AW'(DEPTH - 1)) state <= ST_DONE;
          else wptr <= wptr + AW'(1);
        end
        ST_DONE: if (rd_valid && rd_next) begin
          if (rword == WW'(WORDS - 1)) begin
            rword <= '0;
            if (rsample == AW'(DEPTH - 1)) rdone <= 1'b1;
            else rsample <= rsample + AW'(1);
          end else begin
            rword <= rword + WW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign full     = (state == ST_DONE);
  assign rd_valid = full & ~rdone;
  assign rd_data  = mem[rsample][32*rword +: 32];
  assign status   = {29'b0,
                     (state == ST_ARMED) | (state == ST_CAPT),
                     (state == ST_CAPT)  | (state == ST_DONE),
                     rd_valid};

  p_soft_clear_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl[1] |=> (status == 32'd0 && !full && !rd_valid));

  p_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !clr) |=> (status == 32'd4));

  p_fire_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !clr && fire) |=> (state == ST_CAPT && wptr == AW'(1)));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !clr && !fire) |=> (status == 32'd4));

  p_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPT && !clr && wptr == AW'(DEPTH - 1)) |=> full);

  p_full_status_r8: assert property (@(posedge clk) disable iff (rst)
    full |-> (status[2:1] == 2'b01));

  p_valid_full_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> full);

  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_next && !clr) |=> ($stable(rd_data) && rd_valid));

  p_disable_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl[0] |=> (status == 32'd0 && !full));

endmodule

// File: tb/tb_logic_capture_ctrl.sv
`timescale 1ns/1ps
module tb_logic_capture_ctrl;
  localparam int CH  = 40;
  localparam int DEP = 8;

  logic          clk = 0;
  logic          rst;
  logic [CH-1:0] probe_in;
  logic          ext_trig;
  logic [31:0]   ctrl;
  logic [255:0]  rise_en, fall_en;
  logic          rd_next;
  logic [31:0]   rd_data, status;
  logic          rd_valid, full;

  int checks = 0, failures = 0;
  logic [31:0] exp_q [$];

  logic_capture_ctrl #(.CHANNELS(CH), .DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .probe_in(probe_in), .ext_trig(ext_trig), .ctrl(ctrl),
    .rise_en(rise_en), .fall_en(fall_en), .rd_next(rd_next),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .status(status));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] pat(input int i, input int s);
    logic [31:0] lo, hi;
    lo = 32'(s) * 32'h0100_0193 + 32'(i) * 32'h9E37_79B1;
    hi = 32'(i) * 32'd7 + 32'(s);
    return {hi[7:0], lo};
  endfunction

  task automatic push_sample(input logic [CH-1:0] v);
    exp_q.push_back(v[31:0]);
    exp_q.push_back({24'b0, v[39:32]});
  endtask

  task automatic arm(input logic [31:0] c, input logic [CH-1:0] base, input logic e);
    @(negedge clk); ctrl = 32'd0; probe_in = base; ext_trig = e;
    @(negedge clk); ctrl = c;
    @(negedge clk); chk("R2 armed status", status, 32'd4);
  endtask

  task automatic quiet(input logic [CH-1:0] v, input logic e, input string req);
    probe_in = v; ext_trig = e;
    @(negedge clk); chk(req, status, 32'd4);
  endtask

  // driver: feeds the trigger sample plus DEP-1 more, pushing expectations
  task automatic capture(input logic [CH-1:0] tv, input logic e, input logic [31:0] c,
                         input int seed, input string req);
    probe_in = tv; ext_trig = e; ctrl = c;
    push_sample(tv);
    for (int i = 1; i < DEP; i++) begin
      @(negedge clk);
      if (i == 1) chk({req, " capture started"}, status, 32'd6);
      probe_in = pat(i, seed);
      push_sample(probe_in);
    end
    @(negedge clk);
    chk("R8 full after last sample", {31'b0, full}, 32'd1);
    chk("R8 status when filled", status, 32'd3);
  endtask

  // monitor: pops the scoreboard as words are produced
  task automatic drain(input string req);
    int n = 0;
    while (rd_valid && n < 4 * DEP) begin
      chk(req, rd_data, (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF);
      rd_next = 1;
      @(negedge clk);
      rd_next = 0;
      n++;
    end
    chk("R9 word count", 32'(n), 32'(2 * DEP));
    chk("R9 scoreboard empty", 32'(exp_q.size()), 32'd0);
    chk("R9 ready bit cleared", status, 32'd2);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; probe_in = '0; ext_trig = 0; ctrl = 32'd1; rd_next = 0;
    rise_en = '0; fall_en = '0;
    rise_en[35] = 1'b1;
    fall_en[2]  = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 32'd0);
    chk("R1 reset full/valid", {30'b0, full, rd_valid}, 32'd0);
    rst = 0;

    // R3 rising on channel 35, R5 unmasked edges ignored
    arm(32'd1, '0, 0);
    quiet(40'h00_0000_0001, 0, "R5 unmasked rise ch0");
    quiet(40'h00_0000_0010, 0, "R5 unmasked edges ch0/ch4");
    quiet(40'h00_0000_0000, 0, "R5 unmasked fall ch4");
    capture(40'h08_1234_5678, 0, 32'd1, 1, "R3");
    drain("R9 read after R3 capture");

    // R4 falling on channel 2
    arm(32'd1, 40'h00_0000_0004, 0);
    quiet(40'h00_0000_0005, 0, "R5 rise on fall-only ch");
    capture(40'hF0_0000_0001, 0, 32'd1, 2, "R4");
    drain("R9 read after R4 capture");

    // R6 external rising, enabled channel edge ignored
    arm(32'h0000_000D, '0, 0);
    quiet(40'h08_0000_0000, 0, "R6 channel edge ignored");
    quiet(40'h00_0000_0000, 0, "R6 channel fall ignored");
    capture(40'h00_0000_0055, 1, 32'h0000_000D, 3, "R6 rising");
    drain("R9 read after R6 rising");

    // R6 external falling
    arm(32'h0000_0005, '0, 1);
    quiet(40'h00_0000_0000, 1, "R6 ext steady high");
    capture(40'h81_0000_00AA, 0, 32'h0000_0005, 4, "R6 falling");
    drain("R9 read after R6 falling");

    // R7 software edge coinciding with an enabled channel edge
    arm(32'd1, '0, 0);
    capture(40'h08_0000_0F0F, 0, 32'h0000_0011, 5, "R7 coincident");
    drain("R9 read after R7 coincident");

    // R1 soft reset from filled state
    @(negedge clk); ctrl = 32'h0000_0013;
    @(negedge clk);
    chk("R1 soft reset status", status, 32'd0);
    chk("R1 soft reset full/valid", {30'b0, full, rd_valid}, 32'd0);

    // R7 held software bit does not fire
    arm(32'h0000_0011, '0, 0);
    quiet(40'h00_0000_0000, 0, "R7 held sw bit");
    quiet(40'h00_0000_0000, 0, "R7 held sw bit");

    // R10 disable in the middle of a capture
    probe_in = 40'h08_0000_0000;
    @(negedge clk); chk("R10 capture running", status, 32'd6);
    @(negedge clk); ctrl = 32'd0;
    @(negedge clk);
    chk("R10 disabled status", status, 32'd0);
    chk("R10 disabled full", {31'b0, full}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule